// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Unit

This block holds the control and status registers of a simple LCD controller and drives its single interrupt line. A host reaches six 32-bit words at byte offsets 0x00 to 0x14 through a one-cycle request port. The words are a control word, three timing words, a status word and a subpanel word. The unit decodes the configuration into fields for the fetch engine: enable, palette-load mode, TFT and mono selects, interrupt mask, panel width and panel height.

The unit keeps three event flags: frame-done, palette-done and sync-error. When the enable bit changes, the unit updates the flags and sends a one-cycle strobe to the fetch engine. The fetch engine reports that a palette load finished or that a sync fault occurred through set pulses. It reports that a frame was redrawn through a pulse that clears the display-invalid marker.

Top module: `lcd_reg_unit`

## Requirements
- R1: After reset, every field and flag is zero, invalid_o is 1 and irq_o is 0. Reads then return 0xFE000C34 at 0x00, 0xFFFFFFFF at 0x04 and 0x08, 0xFC000000 at 0x0C, and 0 at 0x10 and 0x14.
- R2: The control word at 0x00 decodes as follows: enable is bit 0, mono is bit 1, interrupt mask is bits 4:3, TFT is bit 7 and palette-load mode is bits 21:20. The bits under 0x01CFF300 are kept as stored. A read returns the stored bits, with TFT in both bit 23 and bit 7, ORed with 0xFE000C34.
- R3: A write to 0x04 sets width to bits 9:0 plus one and keeps bits 31:10. A read returns the kept bits in place, ORed with (width - 1) computed on 32 bits, ORed with 0xF.
- R4: Offset 0x08 holds the height in the same way as R3, but without the 0xF pad. Offset 0x0C stores the whole word and reads it back ORed with 0xFC000000.
- R5: A read of 0x10 returns frame-done in bit 0, sync-error in bit 2 and palette-done in bit 6. Writes to 0x10 change nothing.
- R6: Offset 0x14 stores the written word ANDed with 0xA1FFFFFF.
- R7: irq_o is 1 exactly when any of these holds: frame-done and mask bit 0 are both set, palette-done and mask bit 1 are both set, or sync-error is set.
- R8: A control write that takes enable from 1 to 0 clears sync-error. It sets frame-done unless the written palette-load mode is 1. en_fall_o pulses for one cycle.
- R9: A control write that takes enable from 0 to 1 clears frame-done and palette-done and pulses en_rise_o for one cycle. A write that leaves enable unchanged produces no strobe.
- R10: Any access to an offset other than the six words defined above produces the following: a read returns 0, a write changes nothing, and err_o pulses for one cycle. Misaligned offsets count as such accesses.
- R11: pal_loaded_i sets palette-done and sync_fault_i sets sync-error. If an enable transition happens in the same cycle, the transition's effect on the flags wins.
- R12: invalid_o stays 1 from reset until redraw_done_i pulses.
- R13: Read data and err_o appear one cycle after the request. rdata_o holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after a read request |
| err_o | output | 1 | Undefined-offset strobe |
| pal_loaded_i | input | 1 | Palette load finished (set pulse) |
| sync_fault_i | input | 1 | Sync fault detected (set pulse) |
| redraw_done_i | input | 1 | Full frame redrawn, clears invalid_o |
| enable_o | output | 1 | Controller enable |
| pal_mode_o | output | 2 | Palette-load mode |
| tft_o | output | 1 | TFT panel select |
| mono_o | output | 1 | Monochrome select |
| width_o | output | SIZE_W+1 | Panel width in pixels |
| height_o | output | SIZE_W+1 | Panel height in lines |
| subpanel_o | output | 32 | Stored subpanel word |
| en_rise_o | output | 1 | Enable went 0 to 1 |
| en_fall_o | output | 1 | Enable went 1 to 0 |
| invalid_o | output | 1 | Display contents invalid |
| irq_o | output | 1 | Interrupt |

## Verification
The assertions assume that the request port carries at most one access per cycle. They also assume that status writes arrive with the fetch engine's set pulses low, so that the status word can be shown to stay unchanged. The stimulus drives every input at the falling edge and holds each pulse for exactly one cycle. It raises a set pulse during a control write only when the write is meant to test which of the two wins (R11).

// File: rtl/lcd_reg_pkg.sv
package lcd_reg_pkg;
  localparam int NUM_REGS = 6;
  localparam int IDX_CTRL = 0;
  localparam int IDX_TIM0 = 1;
  localparam int IDX_TIM1 = 2;
  localparam int IDX_TIM2 = 3;
  localparam int IDX_STAT = 4;
  localparam int IDX_SUBP = 5;

  localparam logic [31:0] CTRL_KEEP_MASK = 32'h01CF_F300;
  localparam logic [31:0] CTRL_RD_PAD    = 32'hFE00_0C34;
  localparam logic [31:0] TIM0_RD_PAD    = 32'h0000_000F;
  localparam logic [31:0] TIM2_RD_PAD    = 32'hFC00_0000;
  localparam logic [31:0] SUBP_MASK      = 32'hA1FF_FFFF;

  localparam int ST_FD_BIT = 0;
  localparam int ST_SE_BIT = 2;
  localparam int ST_PD_BIT = 6;

  typedef struct packed {
    logic fd;
    logic pd;
    logic se;
  } flags_t;
endpackage

// File: rtl/lcd_reg_decode.sv
module lcd_reg_decode
  import lcd_reg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_REGS-1:0] sel_o,
  output logic                hit_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign sel_o[i] = (addr_i == ADDR_W'(i * 4));
  end
  assign hit_o = |sel_o;
endmodule

// File: rtl/lcd_reg_cfg.sv
module lcd_reg_cfg
  import lcd_reg_pkg::*;
#(
  parameter int SIZE_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [NUM_REGS-1:0] sel_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         ctrl_rd_o,
  output logic [31:0]         tim0_rd_o,
  output logic [31:0]         tim1_rd_o,
  output logic [31:0]         tim2_rd_o,
  output logic [31:0]         subp_o,
  output logic                enable_o,
  output logic                mono_o,
  output logic                tft_o,
  output logic [1:0]          imask_o,
  output logic [1:0]          plm_o,
  output logic [SIZE_W:0]     width_o,
  output logic [SIZE_W:0]     height_o,
  output logic                en_rise_p_o,
  output logic                en_fall_p_o,
  output logic [1:0]          plm_next_o
);
  localparam int HI_W = 32 - SIZE_W;

  logic            en_q, mono_q, tft_q;
  logic [1:0]      imask_q, plm_q;
  logic [31:0]     extra_q, tim2_q, subp_q;
  logic [HI_W-1:0] tim0_hi_q, tim1_hi_q;
  logic [SIZE_W:0] width_q, height_q;

  logic wr_ctrl, wr_tim0, wr_tim1;
  assign wr_ctrl = wr_i & sel_i[IDX_CTRL];
  assign wr_tim0 = wr_i & sel_i[IDX_TIM0];
  assign wr_tim1 = wr_i & sel_i[IDX_TIM1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      mono_q    <= 1'b0;
      tft_q     <= 1'b0;
      imask_q   <= '0;
      plm_q     <= '0;
      extra_q   <= '0;
      tim0_hi_q <= '0;
      tim1_hi_q <= '0;
      width_q   <= '0;
      height_q  <= '0;
      tim2_q    <= '0;
      subp_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q    <= wdata_i[0];
        mono_q  <= wdata_i[1];
        imask_q <= wdata_i[4:3];
        tft_q   <= wdata_i[7];
        plm_q   <= wdata_i[21:20];
        extra_q <= wdata_i & CTRL_KEEP_MASK;
      end
      if (wr_tim0) begin
        tim0_hi_q <= wdata_i[31:SIZE_W];
        width_q   <= {1'b0, wdata_i[SIZE_W-1:0]} + (SIZE_W+1)'(1);
      end
      if (wr_tim1) begin
        tim1_hi_q <= wdata_i[31:SIZE_W];
        height_q  <= {1'b0, wdata_i[SIZE_W-1:0]} + (SIZE_W+1)'(1);
      end
      if (wr_i & sel_i[IDX_TIM2]) tim2_q <= wdata_i;
      if (wr_i & sel_i[IDX_SUBP]) subp_q <= wdata_i & SUBP_MASK;
    end
  end

  // transitions are seen at the write, before the new value lands
  assign en_rise_p_o = wr_ctrl &  wdata_i[0] & ~en_q;
  assign en_fall_p_o = wr_ctrl & ~wdata_i[0] &  en_q;
  assign plm_next_o  = wdata_i[21:20];

  assign ctrl_rd_o = (32'(tft_q) << 23) | (32'(plm_q) << 20) | (32'(tft_q) << 7)
                   | (32'(imask_q) << 3) | (32'(mono_q) << 1) | 32'(en_q)
                   | extra_q | CTRL_RD_PAD;
  // size field reads back as a 32-bit (size - 1), so a zero size shows all ones
  assign tim0_rd_o = {tim0_hi_q, SIZE_W'(0)} | (32'(width_q) - 32'd1) | TIM0_RD_PAD;
  assign tim1_rd_o = {tim1_hi_q, SIZE_W'(0)} | (32'(height_q) - 32'd1);
  assign tim2_rd_o = tim2_q | TIM2_RD_PAD;
  assign subp_o    = subp_q;

  assign enable_o = en_q;
  assign mono_o   = mono_q;
  assign tft_o    = tft_q;
  assign imask_o  = imask_q;
  assign plm_o    = plm_q;
  assign width_o  = width_q;
  assign height_o = height_q;

  // R3
  width_plus_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tim0 |=> width_o == ({1'b0, $past(wdata_i[SIZE_W-1:0])} + (SIZE_W+1)'(1)));
  // R2
  enable_follows_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> enable_o == $past(wdata_i[0]));
endmodule

// File: rtl/lcd_reg_flags.sv
module lcd_reg_flags
  import lcd_reg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_rise_p_i,
  input  logic       en_fall_p_i,
  input  logic [1:0] plm_next_i,
  input  logic [1:0] imask_i,
  input  logic       pal_loaded_i,
  input  logic       sync_fault_i,
  input  logic       redraw_done_i,
  output flags_t     flags_o,
  output logic       en_rise_o,
  output logic       en_fall_o,
  output logic       invalid_o,
  output logic       irq_o
);
  flags_t flags_q, flags_d;
  logic   rise_q, fall_q, invalid_q;

  always_comb begin
    flags_d = flags_q;
    if (pal_loaded_i) flags_d.pd = 1'b1;
    if (sync_fault_i) flags_d.se = 1'b1;
    // an enable transition overrides the set pulses
    if (en_fall_p_i) begin
      flags_d.se = 1'b0;
      if (plm_next_i != 2'd1) flags_d.fd = 1'b1;
    end else if (en_rise_p_i) begin
      flags_d.fd = 1'b0;
      flags_d.pd = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q   <= '0;
      rise_q    <= 1'b0;
      fall_q    <= 1'b0;
      invalid_q <= 1'b1;
    end else begin
      flags_q <= flags_d;
      rise_q  <= en_rise_p_i;
      fall_q  <= en_fall_p_i;
      if (redraw_done_i) invalid_q <= 1'b0;
    end
  end

  assign flags_o   = flags_q;
  assign en_rise_o = rise_q;
  assign en_fall_o = fall_q;
  assign invalid_o = invalid_q;
  assign irq_o     = (flags_q.fd & imask_i[0]) | (flags_q.pd & imask_i[1]) | flags_q.se;

  // R8
  fall_clears_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_fall_o |-> !flags_o.se);
  // R9
  rise_clears_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_rise_o |-> (!flags_o.fd && !flags_o.pd));
  // R11
  sync_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_fault_i && !en_fall_p_i) |=> flags_o.se);
  // R7
  sync_raises_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o.se |-> irq_o);
endmodule

// File: rtl/lcd_reg_unit.sv
module lcd_reg_unit
  import lcd_reg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SIZE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              err_o,
  input  logic              pal_loaded_i,
  input  logic              sync_fault_i,
  input  logic              redraw_done_i,
  output logic              enable_o,
  output logic [1:0]        pal_mode_o,
  output logic              tft_o,
  output logic              mono_o,
  output logic [SIZE_W:0]   width_o,
  output logic [SIZE_W:0]   height_o,
  output logic [31:0]       subpanel_o,
  output logic              en_rise_o,
  output logic              en_fall_o,
  output logic              invalid_o,
  output logic              irq_o
);
  logic [NUM_REGS-1:0] sel;
  logic                hit, wr, rd;
  logic [31:0]         ctrl_rd, tim0_rd, tim1_rd, tim2_rd, stat_rd, rd_word;
  logic [1:0]          imask, plm_next;
  logic                rise_p, fall_p;
  flags_t              flags;
  logic [31:0]         rdata_q;
  logic                err_q;

  lcd_reg_decode #(.ADDR_W(ADDR_W)) i_decode (
    .addr_i (addr_i),
    .sel_o  (sel),
    .hit_o  (hit)
  );

  assign wr = req_i & we_i & hit;
  assign rd = req_i & ~we_i;

  lcd_reg_cfg #(.SIZE_W(SIZE_W)) i_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr),
    .sel_i       (sel),
    .wdata_i     (wdata_i),
    .ctrl_rd_o   (ctrl_rd),
    .tim0_rd_o   (tim0_rd),
    .tim1_rd_o   (tim1_rd),
    .tim2_rd_o   (tim2_rd),
    .subp_o      (subpanel_o),
    .enable_o    (enable_o),
    .mono_o      (mono_o),
    .tft_o       (tft_o),
    .imask_o     (imask),
    .plm_o       (pal_mode_o),
    .width_o     (width_o),
    .height_o    (height_o),
    .en_rise_p_o (rise_p),
    .en_fall_p_o (fall_p),
    .plm_next_o  (plm_next)
  );

  lcd_reg_flags i_flags (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_rise_p_i   (rise_p),
    .en_fall_p_i   (fall_p),
    .plm_next_i    (plm_next),
    .imask_i       (imask),
    .pal_loaded_i  (pal_loaded_i),
    .sync_fault_i  (sync_fault_i),
    .redraw_done_i (redraw_done_i),
    .flags_o       (flags),
    .en_rise_o     (en_rise_o),
    .en_fall_o     (en_fall_o),
    .invalid_o     (invalid_o),
    .irq_o         (irq_o)
  );

  always_comb begin
    stat_rd = '0;
    stat_rd[ST_FD_BIT] = flags.fd;
    stat_rd[ST_SE_BIT] = flags.se;
    stat_rd[ST_PD_BIT] = flags.pd;
  end

  always_comb begin
    rd_word = '0;
    if (sel[IDX_CTRL]) rd_word = ctrl_rd;
    if (sel[IDX_TIM0]) rd_word = tim0_rd;
    if (sel[IDX_TIM1]) rd_word = tim1_rd;
    if (sel[IDX_TIM2]) rd_word = tim2_rd;
    if (sel[IDX_STAT]) rd_word = stat_rd;
    if (sel[IDX_SUBP]) rd_word = subpanel_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (rd) rdata_q <= rd_word;
      err_q <= req_i & ~hit;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  // R10
  undef_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !hit) |=> (err_o && rdata_o == 32'd0));
  // R5
  status_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel[IDX_STAT] && !pal_loaded_i && !sync_fault_i) |=> $stable(flags));
  // R6
  subpanel_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && sel[IDX_SUBP]) |=> (rdata_o & ~SUBP_MASK) == 32'd0);
  // R13
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
endmodule

// File: tb/test_lcd_reg_unit.sv
`timescale 1ns/1ps
module test_lcd_reg_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        pal_loaded = 1'b0, sync_fault = 1'b0, redraw_done = 1'b0;
  logic [31:0] rdata, subpanel;
  logic        err, enable, tft, mono, en_rise, en_fall, invalid, irq;
  logic [1:0]  pal_mode;
  logic [10:0] width, height;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lcd_reg_unit i_lcd_reg_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err),
    .pal_loaded_i(pal_loaded), .sync_fault_i(sync_fault), .redraw_done_i(redraw_done),
    .enable_o(enable), .pal_mode_o(pal_mode), .tft_o(tft), .mono_o(mono),
    .width_o(width), .height_o(height), .subpanel_o(subpanel),
    .en_rise_o(en_rise), .en_fall_o(en_fall), .invalid_o(invalid), .irq_o(irq)
  );

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares read results one cycle after each read request
  logic mon_rd = 1'b0;
  always @(posedge clk) mon_rd <= rst_n && req && !we;
  always @(negedge clk) begin
    if (mon_rd) begin
      if (sb_q.size() == 0) begin
        chk("R13 unexpected read result", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.tag, rdata, e.data);
        chk({e.tag, " err"}, 32'(err), 32'(e.err));
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input bit e, input string tag);
    sb_q.push_back('{exp, e, tag});
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; pal_loaded = 1'b0; sync_fault = 1'b0;
  endtask

  task automatic pulse_pal();
    pal_loaded = 1'b1; @(negedge clk); pal_loaded = 1'b0;
  endtask

  task automatic pulse_sync();
    sync_fault = 1'b1; @(negedge clk); sync_fault = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 invalid", 32'(invalid), 1);
    chk("R1 enable", 32'(enable), 0);
    chk("R1 width", 32'(width), 0);
    rd(8'h00, 32'hFE000C34, 0, "R1 ctrl");
    rd(8'h04, 32'hFFFFFFFF, 0, "R1 tim0");
    rd(8'h08, 32'hFFFFFFFF, 0, "R1 tim1");
    rd(8'h0C, 32'hFC000000, 0, "R1 tim2");
    rd(8'h10, 32'h0, 0, "R1 status");
    rd(8'h14, 32'h0, 0, "R1 subpanel");

    // R2 control decode, enable stays 0 so no strobe (R9)
    wr(8'h00, 32'hFFFFFFFE);
    chk("R9 no rise strobe", 32'(en_rise), 0);
    chk("R2 tft", 32'(tft), 1);
    chk("R2 mono", 32'(mono), 1);
    chk("R2 plm", 32'(pal_mode), 3);
    rd(8'h00, 32'hFFFFFFBE, 0, "R2 ctrl all");

    // R3 / R4 timing words
    wr(8'h04, 32'hABCDE005);
    chk("R3 width", 32'(width), 6);
    rd(8'h04, 32'hABCDE00F, 0, "R3 tim0");
    wr(8'h04, 32'h000003FF);
    chk("R3 width max", 32'(width), 1024);
    wr(8'h08, 32'h00000FFF);
    chk("R4 height max", 32'(height), 1024);
    rd(8'h08, 32'h00000FFF, 0, "R4 tim1");
    wr(8'h08, 32'h0);
    chk("R4 height min", 32'(height), 1);
    rd(8'h08, 32'h0, 0, "R4 tim1 zero");
    wr(8'h0C, 32'h12345678);
    rd(8'h0C, 32'hFE345678, 0, "R4 tim2");

    // R6 subpanel
    wr(8'h14, 32'hFFFFFFFF);
    rd(8'h14, 32'hA1FFFFFF, 0, "R6 subpanel");
    chk("R6 subpanel_o", subpanel, 32'hA1FFFFFF);

    // R11 / R7 flags and irq (mask = 3)
    pulse_pal();
    chk("R7 irq pd masked in", 32'(irq), 1);
    rd(8'h10, 32'h40, 0, "R11 pd set");
    wr(8'h00, 32'h00000008);
    chk("R7 irq pd masked out", 32'(irq), 0);
    rd(8'h00, 32'hFE000C3C, 0, "R2 ctrl mask1");
    pulse_sync();
    chk("R7 irq sync unmasked", 32'(irq), 1);

    // R5 status write ignored
    wr(8'h10, 32'hFFFFFFFF);
    chk("R5 no err", 32'(err), 0);
    rd(8'h10, 32'h44, 0, "R5 status after write");

    // R9 rise
    wr(8'h00, 32'h00000001);
    chk("R9 rise strobe", 32'(en_rise), 1);
    chk("R9 enable", 32'(enable), 1);
    rd(8'h10, 32'h04, 0, "R9 rise clears done");
    chk("R9 strobe single", 32'(en_rise), 0);
    wr(8'h00, 32'h00000001);
    chk("R9 no rerise", 32'(en_rise), 0);
    pulse_pal();

    // R8 fall, plm 0
    wr(8'h00, 32'h00000008);
    chk("R8 fall strobe", 32'(en_fall), 1);
    chk("R7 irq fd", 32'(irq), 1);
    rd(8'h10, 32'h41, 0, "R8 fall plm0");

    // R8 fall with plm 1
    wr(8'h00, 32'h00100001);
    rd(8'h10, 32'h0, 0, "R9 rise plm1");
    chk("R7 irq low", 32'(irq), 0);
    wr(8'h00, 32'h00100000);
    chk("R8 fall strobe plm1", 32'(en_fall), 1);
    rd(8'h10, 32'h0, 0, "R8 fall plm1 no fd");

    // R11 transition wins over set pulses
    pal_loaded = 1'b1;
    wr(8'h00, 32'h00000001);
    rd(8'h10, 32'h0, 0, "R11 rise beats pd");
    sync_fault = 1'b1;
    wr(8'h00, 32'h00000000);
    rd(8'h10, 32'h01, 0, "R11 fall beats se");

    // R10 undefined offsets
    rd(8'h18, 32'h0, 1, "R10 read 0x18");
    rd(8'h06, 32'h0, 1, "R10 read misaligned");
    wr(8'h1C, 32'h0);
    chk("R10 write err", 32'(err), 1);
    rd(8'h14, 32'hA1FFFFFF, 0, "R10 write dropped");
    chk("R10 err single", 32'(err), 0);

    // R12 invalid marker
    chk("R12 invalid held", 32'(invalid), 1);
    redraw_done = 1'b1; @(negedge clk); redraw_done = 1'b0;
    chk("R12 invalid cleared", 32'(invalid), 0);

    repeat (2) @(negedge clk);
    chk("R13 scoreboard drained", 32'(sb_q.size()), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule